// File: doc/BRIEF.md
# Compare-Capable Integer ALU

This block is a 32-bit integer arithmetic and logic unit. Each cycle it takes two operands and a 5-bit function code, and it registers the 32-bit result on the next rising clock edge. It covers:

- add and subtract;
- unsigned and signed ordering tests;
- equality and inequality tests;
- six tests of operand A against zero;
- the four bitwise operations OR, AND, XOR and NOR.

One adder, 33 bits wide, handles add, subtract and both ordering tests. For the ordering tests, the top bit of the difference is the answer.

A parameter chooses how that adder forms its carries:

- a plain ripple chain; or
- a lookahead structure in groups of four bits, where every carry inside a group comes straight from the group's incoming carry.

Both choices must give identical results. A pipeline or a test harness uses the block by presenting the operands and a code, then reading the result one cycle later. Every test operation returns 0 or 1 in bit 0, and all upper bits are clear. The block raises no flags.

Top module: `cmp_alu`

## Requirements
- R1: Code 00010 returns (A + B) mod 2^32.
- R2: Code 00011 returns (A - B) mod 2^32.
- R3: Code 00100 returns 1 when A < B as unsigned numbers, else 0.
- R4: Code 00101 returns 1 when A < B as two's-complement numbers, else 0.
- R5: Code 00110 returns 1 when A equals B. Code 00111 returns 1 when they differ.
- R6: Codes 01000 (A<0), 01001 (A<=0), 01010 (A==0), 01011 (A!=0), 01100 (A>=0) and 01101 (A>0) treat A as signed. They ignore B, so changing only B leaves their result unchanged.
- R7: Codes 01110, 01111, 10001 and 10010 return A|B, A&B, A^B and ~(A|B).
- R8: Code 00000, and every code not listed above, returns 0.
- R9: Every test code (00100 through 01101) returns its answer in bit 0, with bits 31..1 zero.
- R10: The result appears one clock edge after its inputs are sampled. A synchronous active-high reset clears it to 0.
- R11: The ripple and lookahead carry settings give the same result for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| func | input | 5 | Function code |
| result | output | 32 | Registered result |

## Verification
The assertions check on every cycle the behaviours that follow directly from the inputs one cycle earlier:
- add and subtract wrap modulo 2^32;
- unsigned ordering and equality give the right answer;
- test results carry no upper bits;
- unlisted codes return zero;
- reset clears the result.

Some behaviours are shown only by the bench's scenarios. These are the agreement between the ripple and lookahead instances, the signed corner operands 0x80000000 and 0xFFFFFFFF, and the fact that the zero tests ignore B when only B changes.

// File: rtl/cmp_alu_pkg.sv
package cmp_alu_pkg;
  localparam int FW = 5;
  typedef logic [FW-1:0] fcode_t;

  localparam fcode_t F_NONE  = 5'b00000;
  localparam fcode_t F_ADD   = 5'b00010;
  localparam fcode_t F_SUB   = 5'b00011;
  localparam fcode_t F_LTU   = 5'b00100;
  localparam fcode_t F_LTS   = 5'b00101;
  localparam fcode_t F_EQ    = 5'b00110;
  localparam fcode_t F_NE    = 5'b00111;
  localparam fcode_t F_AZ_LT = 5'b01000;
  localparam fcode_t F_AZ_LE = 5'b01001;
  localparam fcode_t F_AZ_EQ = 5'b01010;
  localparam fcode_t F_AZ_NE = 5'b01011;
  localparam fcode_t F_AZ_GE = 5'b01100;
  localparam fcode_t F_AZ_GT = 5'b01101;
  localparam fcode_t F_OR    = 5'b01110;
  localparam fcode_t F_AND   = 5'b01111;
  localparam fcode_t F_XOR   = 5'b10001;
  localparam fcode_t F_NOR   = 5'b10010;

  // Test codes occupy a contiguous range.
  function automatic logic is_test(fcode_t f);
    return (f >= F_LTU) && (f <= F_AZ_GT);
  endfunction

  function automatic logic is_logic(fcode_t f);
    return (f == F_OR) || (f == F_AND) || (f == F_XOR) || (f == F_NOR);
  endfunction

  function automatic logic is_known(fcode_t f);
    return (f == F_ADD) || (f == F_SUB) || is_test(f) || is_logic(f);
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int AW        = 33,
  parameter bit LOOKAHEAD = 1'b0,
  parameter int GRP       = 4
) (
  input  logic [AW-1:0] x,
  input  logic [AW-1:0] y,
  input  logic          sub,
  output logic [AW-1:0] sum
);
  localparam int NGRP = (AW + GRP - 1) / GRP;

  logic [AW-1:0] yy;
  logic [AW-1:0] carry;

  assign yy  = sub ? ~y : y;
  assign sum = x ^ yy ^ carry;

  generate
    if (LOOKAHEAD) begin : g_la
      logic [AW-1:0] prp;
      logic [AW-1:0] gen;
      assign prp = x | yy;
      assign gen = x & yy;

      always_comb begin : la_blk
        logic [AW:0] cv;
        logic        acc;
        logic        pp;
        cv    = '0;
        cv[0] = sub;
        for (int gi = 0; gi < NGRP; gi++) begin
          for (int k = 0; k < GRP; k++) begin
            if (gi * GRP + k < AW) begin
              // Sum of products back to the group's incoming carry.
              acc = 1'b0;
              pp  = 1'b1;
              for (int j = gi * GRP + k; j >= gi * GRP; j--) begin
                acc = acc | (gen[j] & pp);
                pp  = pp & prp[j];
              end
              cv[gi * GRP + k + 1] = acc | (pp & cv[gi * GRP]);
            end
          end
        end
        carry = cv[AW-1:0];
      end
    end else begin : g_rc
      always_comb begin : rc_blk
        logic c;
        c = sub;
        for (int i = 0; i < AW; i++) begin
          carry[i] = c;
          c = (x[i] & yy[i]) | (c & (x[i] | yy[i]));
        end
      end
    end
  endgenerate
endmodule

// File: rtl/alu_test_unit.sv
module alu_test_unit
  import cmp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  fcode_t        func,
  input  logic          diff_top,
  output logic          flag
);
  logic a_zero;
  logic a_neg;

  assign a_zero = (a == '0);
  assign a_neg  = a[DW-1];

  always_comb begin
    unique case (func)
      F_LTU, F_LTS: flag = diff_top;
      F_EQ:         flag = (a == b);
      F_NE:         flag = (a != b);
      F_AZ_LT:      flag = a_neg;
      F_AZ_LE:      flag = a_neg | a_zero;
      F_AZ_EQ:      flag = a_zero;
      F_AZ_NE:      flag = ~a_zero;
      F_AZ_GE:      flag = ~a_neg;
      F_AZ_GT:      flag = ~a_neg & ~a_zero;
      default:      flag = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import cmp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  fcode_t        func,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (func)
      F_OR:    y = a | b;
      F_AND:   y = a & b;
      F_XOR:   y = a ^ b;
      F_NOR:   y = ~(a | b);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/cmp_alu.sv
module cmp_alu
  import cmp_alu_pkg::*;
#(
  parameter int DW        = 32,
  parameter bit LOOKAHEAD = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [4:0]    func,
  output logic [DW-1:0] result
);
  localparam int AW = DW + 1;

  logic          ext_sgn;
  logic          do_sub;
  logic [AW-1:0] xa;
  logic [AW-1:0] xb;
  logic [AW-1:0] sum;
  logic          flag;
  logic [DW-1:0] bw;
  logic [DW-1:0] nxt;

  // Sign extension only for the signed ordering test.
  assign ext_sgn = (func == F_LTS);
  assign do_sub  = (func != F_ADD);
  assign xa      = {ext_sgn & op_a[DW-1], op_a};
  assign xb      = {ext_sgn & op_b[DW-1], op_b};

  alu_addsub #(.AW(AW), .LOOKAHEAD(LOOKAHEAD), .GRP(4)) u_add (
    .x(xa), .y(xb), .sub(do_sub), .sum(sum)
  );

  alu_test_unit #(.DW(DW)) u_test (
    .a(op_a), .b(op_b), .func(func), .diff_top(sum[AW-1]), .flag(flag)
  );

  alu_bitwise #(.DW(DW)) u_bw (
    .a(op_a), .b(op_b), .func(func), .y(bw)
  );

  always_comb begin
    if (func == F_ADD || func == F_SUB) nxt = sum[DW-1:0];
    else if (is_test(func))             nxt = {{(DW-1){1'b0}}, flag};
    else                                nxt = bw;
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= nxt;
  end
endmodule

// File: rtl/cmp_alu_chk.sv
module cmp_alu_chk
  import cmp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic [4:0]    func,
  input logic [DW-1:0] result
);
  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (func == F_ADD) |=> (result == DW'($past(op_a) + $past(op_b)))); // R1

  AST_SUB_WRAP: assert property (@(posedge clk) disable iff (rst)
    (func == F_SUB) |=> (result == DW'($past(op_a) - $past(op_b)))); // R2

  AST_LTU_BIT: assert property (@(posedge clk) disable iff (rst)
    (func == F_LTU) |=> (result[0] == ($past(op_a) < $past(op_b)))); // R3

  AST_EQ_BIT: assert property (@(posedge clk) disable iff (rst)
    (func == F_EQ) |=> (result[0] == ($past(op_a) == $past(op_b)))); // R5

  AST_UNLISTED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!is_known(func)) |=> (result == '0)); // R8

  AST_TEST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    is_test(func) |=> (result[DW-1:1] == '0)); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result == '0)); // R10
endmodule

bind cmp_alu cmp_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .func(func), .result(result)
);

// File: tb/tb_cmp_alu.sv
module tb_cmp_alu;
  localparam int DW = 32;

  typedef struct {
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  f;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [4:0]  func = '0;
  logic [31:0] res_rc;
  logic [31:0] res_la;

  int n_cmp = 0;
  int n_bad = 0;
  item_t sb[$];

  always #10 clk = ~clk; // 50 MHz

  cmp_alu #(.DW(DW), .LOOKAHEAD(1'b0)) dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .func(func), .result(res_rc)
  );
  cmp_alu #(.DW(DW), .LOOKAHEAD(1'b1)) dut_la (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .func(func), .result(res_la)
  );

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic [4:0] f);
    logic t;
    t = 1'b0;
    case (f)
      5'd2:  return a + b;
      5'd3:  return a - b;
      5'd4:  t = a < b;
      5'd5:  t = $signed(a) < $signed(b);
      5'd6:  t = a == b;
      5'd7:  t = a != b;
      5'd8:  t = $signed(a) < 0;
      5'd9:  t = $signed(a) <= 0;
      5'd10: t = a == 0;
      5'd11: t = a != 0;
      5'd12: t = $signed(a) >= 0;
      5'd13: t = $signed(a) > 0;
      5'd14: return a | b;
      5'd15: return a & b;
      5'd17: return a ^ b;
      5'd18: return ~(a | b);
      default: return 32'd0;
    endcase
    return {31'd0, t};
  endfunction

  function automatic string tag_of(logic [4:0] f);
    case (f)
      5'd2: return "R1";
      5'd3: return "R2";
      5'd4: return "R3 R9";
      5'd5: return "R4 R9";
      5'd6, 5'd7: return "R5 R9";
      5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13: return "R6 R9";
      5'd14, 5'd15, 5'd17, 5'd18: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: presents one operation and queues its expected result.
  task automatic drive(logic [31:0] a, logic [31:0] b, logic [4:0] f);
    item_t it;
    @(negedge clk);
    op_a = a; op_b = b; func = f;
    it.a = a; it.b = b; it.f = f;
    it.exp = model(a, b, f);
    it.tag = tag_of(f);
    sb.push_back(it);
  endtask

  // Monitor: after each capture edge, compares both carry variants.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, res_rc, it.exp);
        check(it.tag, res_la, it.exp);
        check("R11", res_la, res_rc);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  logic [31:0] corner [6];
  initial begin
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
    corner[4] = 32'hFFFF_FFFF; corner[5] = 32'h5555_AAAA;

    // R10: reset holds the result at zero even with an add pending.
    op_a = 32'h1234_5678; op_b = 32'h1111_1111; func = 5'd2;
    repeat (3) @(posedge clk);
    #2;
    check("R10 reset", res_rc, 32'd0);
    check("R10 reset", res_la, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // Corner operands across every code, including unlisted ones (R8).
    for (int f = 0; f < 32; f++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          drive(corner[i], corner[j], 5'(f));

    // Named boundary cases.
    drive(32'hFFFF_FFFF, 32'h0000_0001, 5'd2);  // R1 wraps to 0
    drive(32'h0000_0000, 32'h0000_0001, 5'd3);  // R2 wraps to all ones
    drive(32'h8000_0000, 32'h7FFF_FFFF, 5'd4);  // R3 unsigned: 0
    drive(32'h8000_0000, 32'h7FFF_FFFF, 5'd5);  // R4 signed: 1
    drive(32'hFFFF_FFFF, 32'h0000_0000, 5'd5);  // R4 -1 < 0
    drive(32'h8000_0000, 32'h0000_0000, 5'd13); // R6 most negative not > 0

    // R6: zero tests with A fixed and only B varying.
    for (int f = 8; f <= 13; f++) begin
      drive(32'h0000_0000, 32'hFFFF_FFFF, 5'(f));
      drive(32'h0000_0000, 32'h8000_0000, 5'(f));
      drive(32'h8000_0001, 32'h0000_0000, 5'(f));
      drive(32'h8000_0001, 32'h7FFF_FFFF, 5'(f));
    end

    // Random vectors over all codes; R11 agreement is checked per item.
    for (int k = 0; k < 3000; k++)
      drive($urandom, (k % 7 == 0) ? 32'($urandom % 4) : $urandom, 5'($urandom % 32));

    @(negedge clk);
    op_a = 32'h0; op_b = 32'h0; func = 5'd0;
    while (sb.size() > 0) @(negedge clk);

    // R10: reset mid-run clears a nonzero result on the next edge.
    op_a = 32'hF0F0_0000; op_b = 32'h0000_0F0F; func = 5'd14;
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R10 mid reset", res_rc, 32'd0);
    check("R10 mid reset", res_la, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule